// File: doc/BRIEF.md
# One-Time-Programmable Fuse Controller with Unlock Handshake

This block sits between a simple register bus and a small one-time-programmable fuse array, which it models as a register array of rows. A host enables processor access through a mode bit. It then loads an operation code, a row address and one or two write-data words, and raises a go bit. The controller runs the operation and reports completion and the armed state in a status register. Completion stays visible until the host drops the go bit again.

Fuse programming is protected. The array only accepts programming after the host has run the arm operation four times in a row, each time with the right key value in the first write-data word. Fuse bits move from 0 to 1 and never back, because a program operation ORs the write data into the stored row. Program time is a fixed base plus a per-bit cost for every bit that the operation newly sets, so a write of all ones is the slowest.

The sequencer has four states. S_IDLE waits for a launch. A launch goes to S_FETCH for a read, to S_BURN for an armed program, and straight to S_HOLD for every other case. S_FETCH always moves on to S_HOLD. S_BURN counts down and commits on zero, then moves to S_HOLD. S_HOLD signals done and returns to S_IDLE once the go bit reads 0.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: After reset every readable register reads 0, including status (done in bit 1, armed in bit 2), and every fuse row holds 0.
- R2: The register at byte offset 0x04 (operation) keeps only bits 5:0 of a write. The register at 0x28 (row address) keeps only bits 15:0. The register at 0x00 (mode) keeps only bit 0. The other offsets are: go at 0x08 (bit 0), status at 0x0C, read data at 0x10 and 0x5C, and write data at 0x2C and 0x64.
- R3: While mode bit 0 is 0, setting the go bit has no effect: done does not rise, no fuse changes, and the unlock progress does not advance.
- R4: A launch happens only when go bit 0 changes from 0 to 1 while the sequencer is idle and mode bit 0 is 1. Done (status bit 1) then rises and stays at 1 for as long as go stays at 1. Done clears once go is written 0.
- R5: The read operation (code 0x00) copies the addressed row into the read-data registers: bits 31:0 go to 0x10 and bits 63:32 go to 0x5C.
- R6: The arm operation (code 0x02), run four times in a row with write-data word 0x2C holding 0xF, 0x4, 0x8 and 0xD in that order, sets armed (status bit 2) when the fourth run completes. Armed is not set before that.
- R7: Any wrong key value, or any other operation launched in between, sends the unlock progress back to its first step, so the full four-value sequence is needed again.
- R8: The disarm operation (code 0x03) clears armed.
- R9: A program operation (code 0x0A) launched while armed is 0 completes with done and leaves every fuse row unchanged.
- R10: An armed program operation ORs {word at 0x64, word at 0x2C} into the addressed row, so a bit at 1 never returns to 0.
- R11: An armed program operation takes exactly PER_BIT_CYC cycles more per newly set bit than one that sets no new bit. Bits that are already at 1 add no time.
- R12: The row is chosen by the low ROW_AW bits of the address register, and the address bits above 15 are discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 8 | Byte offset of the write |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 8 | Byte offset of the read |
| reg_rdata | output | 32 | Read data for reg_raddr (combinational) |

## Verification
The hardest situation to reach is an unlock attempt that is broken partway through, either by a wrong key at one of the later steps or by another operation slipped between two correct steps. After such a break, the next correct values must not complete the arming. The bench drives directed interrupted sequences before the first full unlock, checks that armed stays clear, and then arms the block properly. The per-bit latency rule needs rows that already hold ones. Constrained random programs therefore keep returning to a small set of rows, and each one's completion time is compared with a reference program that sets no new bits.

// File: rtl/otp_pkg.sv
package otp_pkg;
    typedef enum logic [1:0] {S_IDLE, S_FETCH, S_BURN, S_HOLD} seq_state_t;

    localparam logic [5:0] OP_READ   = 6'h00;
    localparam logic [5:0] OP_ARM    = 6'h02;
    localparam logic [5:0] OP_DISARM = 6'h03;
    localparam logic [5:0] OP_BURN   = 6'h0A;

    localparam logic [7:0] OFF_MODE   = 8'h00;
    localparam logic [7:0] OFF_OPCODE = 8'h04;
    localparam logic [7:0] OFF_GO     = 8'h08;
    localparam logic [7:0] OFF_STAT   = 8'h0C;
    localparam logic [7:0] OFF_RD0    = 8'h10;
    localparam logic [7:0] OFF_ADDR   = 8'h28;
    localparam logic [7:0] OFF_WD0    = 8'h2C;
    localparam logic [7:0] OFF_RD1    = 8'h5C;
    localparam logic [7:0] OFF_WD1    = 8'h64;

    // key expected at each unlock step
    function automatic logic [31:0] unlock_key(input logic [1:0] step);
        unique case (step)
            2'd0: unlock_key = 32'hF;
            2'd1: unlock_key = 32'h4;
            2'd2: unlock_key = 32'h8;
            2'd3: unlock_key = 32'hD;
        endcase
    endfunction

    function automatic logic [7:0] wd_offset(input int w);
        wd_offset = (w == 0) ? OFF_WD0 : OFF_WD1;
    endfunction
endpackage

// File: rtl/otp_unlock.sv
module otp_unlock
    import otp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        launch,
    input  logic [5:0]  opcode,
    input  logic [31:0] key_word,
    output logic        armed
);
    logic [1:0] step;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step  <= 2'd0;
            armed <= 1'b0;
        end else if (launch) begin
            if (opcode == OP_ARM) begin
                if (key_word == unlock_key(step)) begin
                    if (step == 2'd3) begin
                        armed <= 1'b1;
                        step  <= 2'd0;
                    end else begin
                        step <= step + 2'd1;
                    end
                end else begin
                    step <= 2'd0;
                end
            end else begin
                step <= 2'd0;
                if (opcode == OP_DISARM) armed <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/otp_fuse_array.sv
module otp_fuse_array #(
    parameter int ROW_AW = 4,
    parameter int ROW_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ROW_AW-1:0] row_sel,
    input  logic              burn_en,
    input  logic [ROW_W-1:0]  burn_bits,
    output logic [ROW_W-1:0]  row_q
);
    localparam int ROWS = 1 << ROW_AW;

    logic [ROW_W-1:0] fuse [ROWS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ROWS; i++) fuse[i] <= '0;
        end else if (burn_en) begin
            fuse[row_sel] <= fuse[row_sel] | burn_bits;
        end
    end

    assign row_q = fuse[row_sel];
endmodule

// File: rtl/otp_seq.sv
module otp_seq
    import otp_pkg::*;
#(
    parameter int ROW_W       = 64,
    parameter int BASE_CYC    = 4,
    parameter int PER_BIT_CYC = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic             go,
    input  logic [5:0]       opcode,
    input  logic             armed,
    input  logic [ROW_W-1:0] cur_row,
    input  logic [ROW_W-1:0] burn_data,
    output logic             idle,
    output logic             done,
    output logic             capture,
    output logic             burn_en
);
    localparam int CW = $clog2(BASE_CYC + PER_BIT_CYC * ROW_W + 1);

    seq_state_t state, state_nx;
    logic [CW-1:0] cnt;
    logic [CW-1:0] burn_load;

    assign burn_load = CW'(BASE_CYC + PER_BIT_CYC * $countones(burn_data & ~cur_row));

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (launch) begin
                if (opcode == OP_READ)               state_nx = S_FETCH;
                else if (opcode == OP_BURN && armed) state_nx = S_BURN;
                else                                 state_nx = S_HOLD;
            end
            S_FETCH: state_nx = S_HOLD;
            S_BURN:  if (cnt == '0) state_nx = S_HOLD;
            S_HOLD:  if (!go) state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            if (state == S_IDLE) cnt <= burn_load;
            else if (state == S_BURN && cnt != '0) cnt <= cnt - 1'b1;
        end
    end

    always_comb begin
        idle    = (state == S_IDLE);
        done    = (state == S_HOLD);
        capture = (state == S_FETCH);
        burn_en = (state == S_BURN) && (cnt == '0);
    end
endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl
    import otp_pkg::*;
#(
    parameter int WORDS       = 2,
    parameter int ROW_AW      = 4,
    parameter int BASE_CYC    = 4,
    parameter int PER_BIT_CYC = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [7:0]  reg_waddr,
    input  logic [31:0] reg_wdata,
    input  logic [7:0]  reg_raddr,
    output logic [31:0] reg_rdata
);
    localparam int ROW_W = 32 * WORDS;

    logic                   cpu_en;
    logic [5:0]             opcode_q;
    logic                   go_q, go_prev;
    logic [15:0]            addr_q;
    logic [WORDS-1:0][31:0] wd_q;
    logic [WORDS-1:0][31:0] rd_q;
    logic                   launch, seq_idle, seq_done, capture, burn_en, armed;
    logic [ROW_W-1:0]       cur_row;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpu_en   <= 1'b0;
            opcode_q <= '0;
            go_q     <= 1'b0;
            go_prev  <= 1'b0;
            addr_q   <= '0;
        end else begin
            go_prev <= go_q;
            if (reg_wr) begin
                unique case (reg_waddr)
                    OFF_MODE:   cpu_en   <= reg_wdata[0];
                    OFF_OPCODE: opcode_q <= reg_wdata[5:0];
                    OFF_GO:     go_q     <= reg_wdata[0];
                    OFF_ADDR:   addr_q   <= reg_wdata[15:0];
                    default: ;
                endcase
            end
        end
    end

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                wd_q[w] <= '0;
                rd_q[w] <= '0;
            end else begin
                if (reg_wr && reg_waddr == wd_offset(w)) wd_q[w] <= reg_wdata;
                if (capture) rd_q[w] <= cur_row[32*w +: 32];
            end
        end
    end

    assign launch = cpu_en && go_q && !go_prev && seq_idle;

    otp_unlock u_unlock (
        .clk(clk), .rst_n(rst_n), .launch(launch), .opcode(opcode_q),
        .key_word(wd_q[0]), .armed(armed)
    );

    otp_fuse_array #(.ROW_AW(ROW_AW), .ROW_W(ROW_W)) u_array (
        .clk(clk), .rst_n(rst_n), .row_sel(addr_q[ROW_AW-1:0]),
        .burn_en(burn_en), .burn_bits(wd_q), .row_q(cur_row)
    );

    otp_seq #(.ROW_W(ROW_W), .BASE_CYC(BASE_CYC), .PER_BIT_CYC(PER_BIT_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .launch(launch), .go(go_q), .opcode(opcode_q),
        .armed(armed), .cur_row(cur_row), .burn_data(wd_q), .idle(seq_idle),
        .done(seq_done), .capture(capture), .burn_en(burn_en)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_raddr)
            OFF_MODE:   reg_rdata = {31'd0, cpu_en};
            OFF_OPCODE: reg_rdata = {26'd0, opcode_q};
            OFF_GO:     reg_rdata = {31'd0, go_q};
            OFF_STAT:   reg_rdata = {29'd0, armed, seq_done, 1'b0};
            OFF_RD0:    reg_rdata = rd_q[0];
            OFF_ADDR:   reg_rdata = {16'd0, addr_q};
            OFF_WD0:    reg_rdata = wd_q[0];
            OFF_RD1:    reg_rdata = (WORDS > 1) ? rd_q[WORDS-1] : '0;
            OFF_WD1:    reg_rdata = (WORDS > 1) ? wd_q[WORDS-1] : '0;
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/otp_fuse_ctrl_chk.sv
module otp_fuse_ctrl_chk
    import otp_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       launch,
    input logic       done,
    input logic       armed,
    input logic       burn_en,
    input logic       go,
    input logic [5:0] opcode
);
    a_r9_burn_needs_armed: assert property (@(posedge clk) disable iff (!rst_n)
        burn_en |-> armed);

    a_r6_arm_only_after_arm_op: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(launch && opcode == OP_ARM));

    a_r4_done_clears_after_go_low: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !go) |=> !done);

    a_r8_disarm_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && opcode == OP_DISARM) |=> !armed);

    a_r4_no_launch_while_done: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> !done);
endmodule

bind otp_fuse_ctrl otp_fuse_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .launch(launch), .done(seq_done), .armed(armed),
    .burn_en(burn_en), .go(go_q), .opcode(opcode_q)
);

// File: tb/tb_otp_fuse_ctrl.sv
module tb_otp_fuse_ctrl;
    localparam int ROW_AW  = 4;
    localparam int ROWS    = 1 << ROW_AW;
    localparam int PER_BIT = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_waddr = '0;
    logic [31:0] reg_wdata = '0;
    logic [7:0]  reg_raddr = '0;
    logic [31:0] reg_rdata;

    int checks = 0;
    int fails  = 0;
    logic [63:0] model [ROWS];
    int lat_ref;

    always #2 clk = ~clk;

    otp_fuse_ctrl #(.WORDS(2), .ROW_AW(ROW_AW), .BASE_CYC(4), .PER_BIT_CYC(PER_BIT)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_raddr = a;
        #1;
        d = reg_rdata;
    endtask

    // launch an operation; returns cycles until done, -1 when done never came
    task automatic run_op(input logic [5:0] op, input logic [31:0] addr,
                          input logic [63:0] data, output int lat);
        logic [31:0] s;
        wr(8'h04, {26'd0, op});
        wr(8'h28, addr);
        wr(8'h2C, data[31:0]);
        wr(8'h64, data[63:32]);
        wr(8'h08, 32'h1);
        lat = -1;
        for (int c = 0; c < 400; c++) begin
            rd(8'h0C, s);
            if (s[1]) begin lat = c; break; end
            @(negedge clk);
        end
        wr(8'h08, 32'h0);
        @(negedge clk);
    endtask

    function automatic bit armed_now();
        return dut.reg_rdata[2];
    endfunction

    task automatic status(output logic [31:0] s);
        rd(8'h0C, s);
    endtask

    task automatic read_row(input logic [31:0] addr, output logic [63:0] row);
        int l;
        logic [31:0] lo, hi;
        run_op(6'h00, addr, 64'd0, l);
        rd(8'h10, lo);
        rd(8'h5C, hi);
        row = {hi, lo};
    endtask

    task automatic arm_seq();
        int l;
        run_op(6'h02, 0, 64'hF, l);
        run_op(6'h02, 0, 64'h4, l);
        run_op(6'h02, 0, 64'h8, l);
        run_op(6'h02, 0, 64'hD, l);
    endtask

    task automatic burn_check(input int row, input logic [31:0] addr, input logic [63:0] d, input string req);
        int l;
        int nb;
        nb = $countones(d & ~model[row]);
        run_op(6'h0A, addr, d, l);
        model[row] = model[row] | d;
        chk({req, " R11 latency"}, 64'(l), 64'(lat_ref + PER_BIT * nb));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] s;
        logic [63:0] row;
        int l;
        void'($urandom(32'h5EED));
        for (int i = 0; i < ROWS; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        begin
            logic [7:0] offs [9] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h28, 8'h2C, 8'h5C, 8'h64};
            for (int i = 0; i < 9; i++) begin
                rd(offs[i], s);
                chk("R1 reset register", 64'(s), 64'd0);
            end
        end

        // R2 field masking
        wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, s); chk("R2 opcode mask", 64'(s), 64'h3F);
        wr(8'h28, 32'h0001_2345); rd(8'h28, s); chk("R2 address mask", 64'(s), 64'h2345);
        wr(8'h00, 32'hFFFF_FFFE); rd(8'h00, s); chk("R2 mode mask", 64'(s), 64'h0);

        // R3 mode clear: go ignored, unlock does not advance
        arm_seq();
        status(s);
        chk("R3 no done/armed with mode clear", 64'(s), 64'd0);
        wr(8'h08, 32'h1);
        repeat (10) @(negedge clk);
        status(s);
        chk("R3 go ignored with mode clear", 64'(s[1]), 64'd0);
        wr(8'h08, 32'h0);
        wr(8'h00, 32'h1);
        run_op(6'h02, 0, 64'h4, l);
        run_op(6'h02, 0, 64'h8, l);
        run_op(6'h02, 0, 64'hD, l);
        status(s);
        chk("R3 earlier steps not counted", 64'(s[2]), 64'd0);

        // R4 done held while go high, cleared after go low
        wr(8'h04, 32'h0);
        wr(8'h08, 32'h1);
        repeat (12) @(negedge clk);
        status(s); chk("R4 done held while go=1", 64'(s[1]), 64'd1);
        wr(8'h08, 32'h0);
        @(negedge clk);
        status(s); chk("R4 done cleared after go=0", 64'(s[1]), 64'd0);

        // R9 program while disarmed changes nothing
        run_op(6'h0A, 3, 64'hFFFF_FFFF_FFFF_FFFF, l);
        chk("R9 disarmed program completes", 64'(l >= 0), 64'd1);
        read_row(3, row); chk("R9 row unchanged", row, 64'd0);

        // R7 interrupted sequences
        run_op(6'h02, 0, 64'hF, l); run_op(6'h02, 0, 64'h4, l);
        run_op(6'h00, 0, 64'd0, l);
        run_op(6'h02, 0, 64'h8, l); run_op(6'h02, 0, 64'hD, l);
        status(s); chk("R7 other op resets progress", 64'(s[2]), 64'd0);
        run_op(6'h02, 0, 64'hF, l); run_op(6'h02, 0, 64'h4, l);
        run_op(6'h02, 0, 64'h7, l); run_op(6'h02, 0, 64'hD, l);
        status(s); chk("R7 wrong key resets progress", 64'(s[2]), 64'd0);
        run_op(6'h02, 0, 64'h4, l); run_op(6'h02, 0, 64'h8, l); run_op(6'h02, 0, 64'hD, l);
        status(s); chk("R7 restart needed", 64'(s[2]), 64'd0);

        // R6 correct sequence
        run_op(6'h02, 0, 64'hF, l); run_op(6'h02, 0, 64'h4, l); run_op(6'h02, 0, 64'h8, l);
        status(s); chk("R6 not armed after three steps", 64'(s[2]), 64'd0);
        run_op(6'h02, 0, 64'hD, l);
        status(s); chk("R6 armed after fourth step", 64'(s[2]), 64'd1);

        // R11 reference latency with no new bits
        run_op(6'h0A, 0, 64'd0, lat_ref);
        chk("R11 reference completes", 64'(lat_ref >= 0), 64'd1);
        burn_check(1, 1, 64'hFF, "R10");
        burn_check(1, 1, 64'hFFFF, "R10 overlap");
        burn_check(2, 2, 64'hFFFF_FFFF_FFFF_FFFF, "R10 all ones");
        read_row(1, row); chk("R5 R10 row1 readback", row, model[1]);
        burn_check(1, 1, 64'd0, "R10 zero data");
        read_row(1, row); chk("R10 bits never cleared", row, 64'hFFFF);
        read_row(2, row); chk("R5 upper word readback", row, 64'hFFFF_FFFF_FFFF_FFFF);

        // R12 address decoding
        burn_check(5, 32'h0001_0015, 64'hA5A5_0000_0000_5A5A, "R12");
        read_row(5, row); chk("R12 row from low address bits", row, model[5]);

        // random programs over a few rows
        for (int it = 0; it < 40; it++) begin
            int r;
            logic [63:0] d;
            r = 8 + ($urandom % 4);
            d = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
            burn_check(r, 32'(r), d, "R10 random");
            read_row(32'(r), row);
            chk("R5 R10 random readback", row, model[r]);
        end

        // R8 disarm then program has no effect
        run_op(6'h03, 0, 64'd0, l);
        status(s); chk("R8 disarm clears armed", 64'(s[2]), 64'd0);
        run_op(6'h0A, 4, 64'hFFFF, l);
        read_row(4, row); chk("R8 R9 no program after disarm", row, 64'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule